// File: doc/BRIEF.md
# Packet Destination Address Translator

This block sits on the packet path between link protocol logic and the system side. Each 104-bit packet that enters carries a 32-bit destination address in bits [39:8]. Only that field is rewritten; every other bit leaves exactly as it arrived, one register stage later. A small configuration write port holds four values: the translation mode, a 12-bit select mask with a 12-bit pattern, a 32-bit offset, and an 8-bit column number.

In the masked mode, the top twelve address bits are replaced only where the select mask is set. In the arithmetic mode, the column number shifted into the top bits is subtracted and the offset is added. A build-time parameter chooses the transmit-side variant. In that variant, the masked mode is replaced by a fixed rearrangement of the address bits.

Both packet ports use a valid/ready handshake. A packet moves on any rising edge where valid and ready are both high. The output holds its valid and data steady for as long as ready stays low. The input is ready whenever the output register is empty or is being drained in the same cycle. No packet is dropped or delivered twice. The translation uses the configuration that is in force in the cycle the packet is accepted.

Top module: `addr_xlate`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and in_ready is 1. All configuration values reset to zero, so the mode is pass-through.
- R2: Mode 2'b00, in configuration word 0 bits [3:2], delivers the destination address unchanged.
- R3: Mode 2'b01 on the receive variant gives result[31:20] = (sel & pat) | (~sel & addr[31:20]) and result[19:0] = addr[19:0].
- R4: Mode 2'b10 on the receive variant gives result = addr − (col << 20) + off, modulo 2^32.
- R5: Mode 2'b11 delivers the address unchanged.
- R6: Packet bits [103:40] and [7:0] leave the block unchanged.
- R7: A packet accepted on a clock edge is presented with out_valid high right after that same edge.
- R8: While out_valid is high and out_ready is low, out_valid and out_pkt stay stable and no new packet is accepted. A packet waiting at the input is accepted on the same edge that drains the output.
- R9: A configuration write on the same edge as a packet acceptance does not affect that packet. The next packet uses the new value.
- R10: On the transmit variant (TX_SIDE=1), mode 2'b01 gives {addr[29:16], (addr[17]|addr[16]) ? 2'b11 : 2'b00, addr[15:0]}. Modes 2'b10 and 2'b11 pass the address unchanged.
- R11: Configuration writes use cfg_idx as follows. Index 0 sets the mode from bits [3:2]. Index 1 sets sel from bits [11:0] and pat from bits [27:16]. Index 2 sets off from all 32 bits. Index 3 sets col from bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input can accept a packet |
| in_pkt | input | 104 | Input packet |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Downstream can take the packet |
| out_pkt | output | 104 | Packet with translated destination address |

## Verification
Two functions can fall in the same cycle: a configuration write and a packet acceptance. The same is true of draining the output and accepting a waiting input. The bench drives a mode change, or an offset change, in the same cycle that a packet is offered. It expects that packet to carry the old translation and the next packet to carry the new one. For back-pressure, the bench holds out_ready low with a second packet waiting. It checks that the first packet stays stable, and that releasing ready delivers the first packet and then the second, each exactly once.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int PKT_W  = 104;
  localparam int ADDR_W = 32;
  localparam int DST_LO = 8;
  localparam int DST_HI = DST_LO + ADDR_W - 1;
  localparam int MASK_W = 12;
  localparam int COL_W  = 8;
  localparam int COL_SH = ADDR_W - MASK_W;

  typedef enum logic [1:0] {
    XM_PASS   = 2'b00,
    XM_STATIC = 2'b01,
    XM_DYN    = 2'b10,
    XM_RSVD   = 2'b11
  } xmode_e;

  typedef struct packed {
    xmode_e              mode;
    logic [MASK_W-1:0]   sel;
    logic [MASK_W-1:0]   pat;
    logic [ADDR_W-1:0]   off;
    logic [COL_W-1:0]    col;
  } xcfg_t;
endpackage

// File: rtl/addr_xlate_cfg.sv
module addr_xlate_cfg
  import addr_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [ADDR_W-1:0] wdata,
  output xcfg_t             cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (idx)
        2'd0: cfg.mode <= xmode_e'(wdata[3:2]);
        2'd1: begin
          cfg.sel <= wdata[MASK_W-1:0];
          cfg.pat <= wdata[16 +: MASK_W];
        end
        2'd2: cfg.off <= wdata;
        default: cfg.col <= wdata[COL_W-1:0];
      endcase
    end
  end

  p_offset_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == 2'd2) |=> (cfg.off == $past(wdata)));
  p_mode_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == 2'd0) |=> (cfg.mode == $past(wdata[3:2])));
endmodule

// File: rtl/addr_xlate_core.sv
module addr_xlate_core
  import addr_xlate_pkg::*;
#(
  parameter bit TX_SIDE = 1'b0
) (
  input  xcfg_t             cfg,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] rx_addr;
  logic [ADDR_W-1:0] tx_addr;
  logic [ADDR_W-1:0] col_term;

  assign col_term = ADDR_W'(cfg.col) << COL_SH;

  always_comb begin
    case (cfg.mode)
      XM_STATIC: rx_addr = {(cfg.sel & cfg.pat) | (~cfg.sel & addr_in[ADDR_W-1:COL_SH]),
                            addr_in[COL_SH-1:0]};
      XM_DYN:    rx_addr = addr_in - col_term + cfg.off;
      default:   rx_addr = addr_in;
    endcase
  end

  always_comb begin
    if (cfg.mode == XM_STATIC)
      tx_addr = {addr_in[29:16], (addr_in[17] | addr_in[16]) ? 2'b11 : 2'b00, addr_in[15:0]};
    else
      tx_addr = addr_in;
  end

  generate
    if (TX_SIDE) begin : g_tx
      assign addr_out = tx_addr;
    end else begin : g_rx
      assign addr_out = rx_addr;
    end
  endgenerate
endmodule

// File: rtl/addr_xlate_stage.sv
module addr_xlate_stage
  import addr_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_pkt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PKT_W-1:0] out_pkt
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkt   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pkt <= in_pkt;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import addr_xlate_pkg::*;
#(
  parameter bit TX_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  out_pkt
);
  xcfg_t             cfg;
  logic [ADDR_W-1:0] new_addr;
  logic [PKT_W-1:0]  xl_pkt;

  addr_xlate_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata), .cfg(cfg)
  );

  addr_xlate_core #(.TX_SIDE(TX_SIDE)) u_core (
    .cfg(cfg), .addr_in(in_pkt[DST_HI:DST_LO]), .addr_out(new_addr)
  );

  assign xl_pkt = {in_pkt[PKT_W-1:DST_HI+1], new_addr, in_pkt[DST_LO-1:0]};

  addr_xlate_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(xl_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt)
  );

  p_other_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_pkt[PKT_W-1:DST_HI+1] == $past(in_pkt[PKT_W-1:DST_HI+1]) &&
       out_pkt[DST_LO-1:0] == $past(in_pkt[DST_LO-1:0])));
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg.mode == XM_PASS && !cfg_we) |=>
      (out_pkt[DST_HI:DST_LO] == $past(in_pkt[DST_HI:DST_LO])));
  p_static_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!TX_SIDE && in_valid && in_ready && cfg.mode == XM_STATIC) |=>
      (out_pkt[DST_LO+COL_SH-1:DST_LO] == $past(in_pkt[DST_LO+COL_SH-1:DST_LO])));
endmodule

// File: tb/test_addr_xlate.sv
module test_addr_xlate;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, in_valid, out_ready;
  logic [1:0] cfg_idx;
  logic [31:0] cfg_wdata;
  logic [103:0] in_pkt;
  logic rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [103:0] rx_out, tx_out;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [1:0] m_mode = 0;
  logic [11:0] m_sel = 0, m_pat = 0;
  logic [31:0] m_off = 0;
  logic [7:0] m_col = 0;

  addr_xlate #(.TX_SIDE(1'b0)) i_addr_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(rx_in_ready), .in_pkt(in_pkt),
    .out_valid(rx_out_valid), .out_ready(out_ready), .out_pkt(rx_out));
  addr_xlate #(.TX_SIDE(1'b1)) i_addr_xlate_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(tx_in_ready), .in_pkt(in_pkt),
    .out_valid(tx_out_valid), .out_ready(out_ready), .out_pkt(tx_out));

  function automatic logic [31:0] rx_exp(input logic [31:0] a);
    case (m_mode)
      2'b01: return {(m_sel & m_pat) | (~m_sel & a[31:20]), a[19:0]};
      2'b10: return a - {4'b0, m_col, 20'b0} + m_off;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] tx_exp(input logic [31:0] a);
    if (m_mode == 2'b01) return {a[29:16], (a[17] | a[16]) ? 2'b11 : 2'b00, a[15:0]};
    return a;
  endfunction

  task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [103:0] mkpkt(input logic [31:0] a);
    logic [31:0] r0, r1;
    r0 = rnd(); r1 = rnd();
    return {r0, r1, rnd(), a, r0[7:0]};
  endfunction

  task automatic apply_model(input logic [1:0] idx, input logic [31:0] d);
    case (idx)
      2'd0: m_mode = d[3:2];
      2'd1: begin m_sel = d[11:0]; m_pat = d[27:16]; end
      2'd2: m_off = d;
      default: m_col = d[7:0];
    endcase
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    apply_model(idx, d);
  endtask

  task automatic xfer(input logic [31:0] a, input string tag);
    logic [103:0] p;
    p = mkpkt(a);
    @(negedge clk);
    in_valid = 1; in_pkt = p;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R7 valid"}, {103'b0, rx_out_valid & tx_out_valid}, 104'd1);
    chk({tag, " rx"}, rx_out, {p[103:40], rx_exp(a), p[7:0]});
    chk({tag, " R10 tx"}, tx_out, {p[103:40], tx_exp(a), p[7:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [103:0] pa, pb;
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; in_valid = 0; in_pkt = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {103'b0, rx_out_valid | tx_out_valid}, 104'd0);
    chk("R1 reset in_ready", {103'b0, rx_in_ready & tx_in_ready}, 104'd1);
    rst_n = 1;
    // R1 / R2 / R6: default mode is pass-through
    for (int i = 0; i < 8; i++) xfer(rnd(), "R1 R2 R6 pass");

    // R3 / R11: sweep select masks and patterns in static mode
    wr(2'd0, 32'h4);
    for (int s = 0; s < 13; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [11:0] sv, pv;
        sv = 12'hFFF >> s;
        pv = (p == 0) ? 12'h000 : (p == 1) ? 12'hFFF : (p == 2) ? 12'hA5C : rnd();
        wr(2'd1, {4'h0, pv, 4'h0, sv});
        for (int k = 0; k < 3; k++) xfer(rnd(), "R3 static");
      end
    end

    // R4 / R11: dynamic mode, borrow and carry corners included
    wr(2'd0, 32'h8);
    for (int c = 0; c < 8; c++) begin
      wr(2'd3, (c == 7) ? 32'hFF : c * 37);
      wr(2'd2, (c == 0) ? 32'hFFFF_FFFF : rnd());
      xfer(32'h0000_0000, "R4 dyn zero");
      xfer(32'hFFFF_FFFF, "R4 dyn ones");
      for (int k = 0; k < 4; k++) xfer(rnd(), "R4 dyn");
    end

    // R5: reserved mode passes through
    wr(2'd0, 32'hC);
    for (int k = 0; k < 6; k++) xfer(rnd(), "R5 mode11");

    // R9: config write in the same cycle as acceptance
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h3); wr(2'd2, 32'h1000_0000);
    pa = mkpkt(32'h1234_5678);
    @(negedge clk);
    in_valid = 1; in_pkt = pa; cfg_we = 1; cfg_idx = 0; cfg_wdata = 32'h8;
    @(negedge clk);
    in_valid = 0; cfg_we = 0;
    chk("R9 old mode used", rx_out, pa);
    apply_model(2'd0, 32'h8);
    xfer(32'h1234_5678, "R9 new mode used");

    // R8: back-pressure, drain and accept on the same edge
    pa = mkpkt(rnd()); pb = mkpkt(rnd());
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_pkt = pa;
    @(negedge clk);
    in_pkt = pb;
    chk("R8 in_ready low when full", {103'b0, rx_in_ready}, 104'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 hold", rx_out, {pa[103:40], rx_exp(pa[39:8]), pa[7:0]});
      chk("R8 valid held", {103'b0, rx_out_valid}, 104'd1);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 second packet", rx_out, {pb[103:40], rx_exp(pb[39:8]), pb[7:0]});
    @(negedge clk);
    chk("R8 no duplicate", {103'b0, rx_out_valid}, 104'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule